// File: doc/BRIEF.md
# Console Main-Bus Address Decoder

This block sits on the 24-bit address bus of a console's main processor. It turns each access into one of six select lines: cartridge ROM, work RAM, the coprocessor window, the I/O chip, the bus-control registers and the video chip. Every access is classified as a byte or word access, and as a read or a write. The memories and peripherals are outside the block. They see the selects, a 16-bit local address and a write word that is already lane-adjusted. In the same cycle they return read data on dedicated input ports.

The block assembles the read word and registers it, so the result is available one cycle after the access. When no device drives the bus, the block supplies the open-bus pattern. Byte reads are steered onto the low lane. Byte-wide devices are mirrored across both lanes on word reads. Accesses that would freeze the real machine set a sticky lockup flag. That flag stays set until reset, and the block keeps decoding afterwards.

Top module: `main_bus_decoder`

## Requirements
- R1: With `req_valid` high, address bits 23:21 choose the target: 0 or 1 is ROM (reads only), 7 is work RAM, 5 is the coprocessor/I-O area and 6 is the video chip. At most one select is high at a time, and none is high while `req_valid` is low.
- R2: In region 7 the whole region mirrors the work RAM. `loc_addr` always carries address bits 15:0, so 0xE12344 and 0xFF2344 reach the same RAM word.
- R3: A read raises `rd_valid` and presents `rd_data` one clock after the cycle in which it was issued. A write leaves `rd_valid` low.
- R4: A byte read from a word-wide source returns bits 15:8 for an even address and bits 7:0 for an odd address, in `rd_data[7:0]`, with `rd_data[15:8]` zero. A word read returns the full word.
- R5: In region 5, bits 20:16 = 0 select the coprocessor. Bits 20:16 = 1 together with bits 15:5 = 0 select the I/O chip. A byte read from either returns its 8-bit value. A word read returns that value on both halves.
- R6: Reads with no driving device return the open-bus word: 0x4E71 for addresses ≥ 0xC00000 and 0x4E00 below that, lane-steered as in R4. These reads cover regions 2 and 3, page 0x00 of region 5 outside the I/O chip, the bus-control pages, and video offsets 0x18–0x1F.
- R7: In region 6 the video chip answers only when (address AND 0xE700E0) = 0xC00000. Unmasked address bits mirror the window.
- R8: Inside the window, offset bits 4:0 decode as follows. 0x00–0x03 is the data port (`vid_port`=0). 0x04–0x07 is the control port (1). 0x08–0x0F is the H/V counter (2), readable only. 0x10–0x17 is the tone generator (3), writable only, and a byte write to it needs an odd address.
- R9: A control-port read returns open-bus bits 15:10 above `vid_rdata[9:0]`. A byte read at an even address therefore gives open-bus bits 7:2 above status bits 9:8.
- R10: `lockup` is set by any access to region 4 or to region 6 outside the window, by a read of the tone generator, and by a write of the H/V counter. Such reads return all ones (0xFFFF for a word, 0x00FF for a byte) and raise no select.
- R11: `lockup` stays high until reset. Later accesses keep decoding and returning data normally.
- R12: The following writes raise no select: writes to ROM, to regions 2–3, to video offsets 0x18–0x1F, even-address byte writes to the tone generator, and even-address byte writes to the I/O chip.
- R13: `out_wdata` copies `req_wdata[7:0]` onto both lanes for byte accesses and passes `req_wdata` through for word accesses.
- R14: In region 5 above the coprocessor window, pages 0x10–0x13, 0x20 and 0x30 (address bits 15:8) select the bus-control registers. A read in page 0x11 replaces open-bus bit 8 with `busack`. Any other page except 0x00 locks up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| rom_rdata | input | 16 | ROM read word |
| wram_rdata | input | 16 | Work RAM read word |
| cop_rdata | input | 8 | Coprocessor window read byte |
| io_rdata | input | 8 | I/O chip read byte |
| vid_rdata | input | 16 | Video port read word |
| busack | input | 1 | Bus-grant status bit |
| sel_rom | output | 1 | ROM select |
| sel_wram | output | 1 | Work RAM select |
| sel_cop | output | 1 | Coprocessor window select |
| sel_io | output | 1 | I/O chip select |
| sel_busctl | output | 1 | Bus-control register select |
| sel_video | output | 1 | Video chip select |
| vid_port | output | 2 | Video sub-port: 0 data, 1 control, 2 H/V, 3 tone |
| loc_addr | output | 16 | Local address (bits 15:0) |
| out_wdata | output | 16 | Lane-adjusted write data |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| lockup | output | 1 | Sticky lockup flag |

## Verification
The bench builds the decoder with its default parameters: a 0xE700E0/0xC00000 video window, a 0x4E71 open-bus word and a 0xC00000 open-bus split. With these values, each open-bus variant can be reached from a single 24-bit address. Both window mirrors and the control-port merge have fixed, hand-computable values. The peripheral inputs are held at distinct constants, so any lane swap, missed duplication or wrong source shows up in `rd_data`.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int LOC_W    = 16;
  localparam int NUM_SEL  = 6;

  localparam int SEL_ROM    = 0;
  localparam int SEL_WRAM   = 1;
  localparam int SEL_COP    = 2;
  localparam int SEL_IO     = 3;
  localparam int SEL_BUSCTL = 4;
  localparam int SEL_VIDEO  = 5;

  typedef enum logic [3:0] {
    SRC_NONE, SRC_ROM, SRC_WRAM, SRC_COP, SRC_IO,
    SRC_BUSCTL, SRC_VDATA, SRC_VCTRL, SRC_OPEN, SRC_ONES
  } src_e;

  typedef enum logic [1:0] {
    VP_DATA = 2'd0, VP_CTRL = 2'd1, VP_HV = 2'd2, VP_TONE = 2'd3
  } vport_e;
endpackage

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
  import mbd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VID_MASK   = 24'hE700E0,
  parameter logic [ADDR_W-1:0] VID_MATCH  = 24'hC00000,
  parameter logic [ADDR_W-1:0] OPEN_SPLIT = 24'hC00000
) (
  input  logic              valid,
  input  logic              write,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_SEL-1:0] sel,
  output src_e              src,
  output vport_e            vport,
  output logic              lock_hit,
  output logic              open_hi,
  output logic              ack_page
);
  localparam int RGN_LSB = ADDR_W - 3;

  logic [2:0]   region;
  logic [4:0]   sub_blk;
  logic [7:0]   page;
  logic         in_window;
  logic [NUM_SEL-1:0] sel_raw;
  logic         lock_raw;

  assign region    = addr[ADDR_W-1:RGN_LSB];
  assign sub_blk   = addr[20:16];
  assign page      = addr[15:8];
  assign in_window = ((addr & VID_MASK) == VID_MATCH);
  assign open_hi   = (addr >= OPEN_SPLIT);

  always_comb begin
    sel_raw  = '0;
    src      = SRC_NONE;
    vport    = VP_DATA;
    lock_raw = 1'b0;
    ack_page = 1'b0;
    unique case (region)
      3'd0, 3'd1: begin
        if (!write) begin
          sel_raw[SEL_ROM] = 1'b1;
          src = SRC_ROM;
        end
      end
      3'd2, 3'd3: begin
        if (!write) src = SRC_OPEN;
      end
      3'd4: begin
        lock_raw = 1'b1;
        src = SRC_ONES;
      end
      3'd5: begin
        if (sub_blk == 5'd0) begin
          sel_raw[SEL_COP] = 1'b1;
          src = SRC_COP;
        end else if (sub_blk == 5'd1 && addr[15:5] == 11'd0) begin
          // only the low write lane reaches the I/O chip
          if (!(write && !word && !addr[0])) sel_raw[SEL_IO] = 1'b1;
          src = SRC_IO;
        end else begin
          unique case (page)
            8'h10, 8'h11, 8'h12, 8'h13, 8'h20, 8'h30: begin
              sel_raw[SEL_BUSCTL] = 1'b1;
              src = SRC_BUSCTL;
              ack_page = (page == 8'h11);
            end
            8'h00: src = SRC_OPEN;
            default: begin
              lock_raw = 1'b1;
              src = SRC_ONES;
            end
          endcase
        end
      end
      3'd6: begin
        if (!in_window) begin
          lock_raw = 1'b1;
          src = SRC_ONES;
        end else begin
          unique case (addr[4:3])
            2'd0: begin
              sel_raw[SEL_VIDEO] = 1'b1;
              vport = addr[2] ? VP_CTRL : VP_DATA;
              src   = addr[2] ? SRC_VCTRL : SRC_VDATA;
            end
            2'd1: begin
              if (write) begin
                lock_raw = 1'b1;
              end else begin
                sel_raw[SEL_VIDEO] = 1'b1;
                vport = VP_HV;
                src   = SRC_VDATA;
              end
            end
            2'd2: begin
              if (!write) begin
                lock_raw = 1'b1;
                src = SRC_ONES;
              end else if (word || addr[0]) begin
                sel_raw[SEL_VIDEO] = 1'b1;
                vport = VP_TONE;
              end
            end
            default: begin
              if (!write) src = SRC_OPEN;
            end
          endcase
        end
      end
      default: begin
        sel_raw[SEL_WRAM] = 1'b1;
        src = SRC_WRAM;
      end
    endcase
  end

  assign sel      = valid ? sel_raw : '0;
  assign lock_hit = valid & lock_raw;
endmodule

// File: rtl/mbd_read_merge.sv
module mbd_read_merge
  import mbd_pkg::*;
#(
  parameter logic [DATA_W-1:0] OPEN_WORD    = 16'h4E71,
  parameter logic [DATA_W-1:0] OPEN_LO_KEEP = 16'hFF00,
  parameter int                CTRL_BITS    = 10
) (
  input  src_e              src,
  input  logic              word,
  input  logic              odd,
  input  logic              open_hi,
  input  logic              ack_page,
  input  logic              busack,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] wram_rdata,
  input  logic [BYTE_W-1:0] cop_rdata,
  input  logic [BYTE_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] vid_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] open_w;
  logic [DATA_W-1:0] busctl_w;
  logic [DATA_W-1:0] ctrl_w;

  function automatic logic [DATA_W-1:0] steer(input logic [DATA_W-1:0] w,
                                              input logic wd, input logic a0);
    if (wd) return w;
    return {{(DATA_W-BYTE_W){1'b0}}, a0 ? w[BYTE_W-1:0] : w[DATA_W-1:BYTE_W]};
  endfunction

  function automatic logic [DATA_W-1:0] mirror(input logic [BYTE_W-1:0] b,
                                               input logic wd);
    return wd ? {b, b} : {{(DATA_W-BYTE_W){1'b0}}, b};
  endfunction

  assign open_w = open_hi ? OPEN_WORD : (OPEN_WORD & OPEN_LO_KEEP);

  always_comb begin
    busctl_w = open_w;
    if (ack_page) busctl_w[BYTE_W] = busack;
  end

  assign ctrl_w = {open_w[DATA_W-1:CTRL_BITS], vid_rdata[CTRL_BITS-1:0]};

  always_comb begin
    unique case (src)
      SRC_ROM:    rdata = steer(rom_rdata, word, odd);
      SRC_WRAM:   rdata = steer(wram_rdata, word, odd);
      SRC_COP:    rdata = mirror(cop_rdata, word);
      SRC_IO:     rdata = mirror(io_rdata, word);
      SRC_BUSCTL: rdata = steer(busctl_w, word, odd);
      SRC_VDATA:  rdata = steer(vid_rdata, word, odd);
      SRC_VCTRL:  rdata = steer(ctrl_w, word, odd);
      SRC_OPEN:   rdata = steer(open_w, word, odd);
      SRC_ONES:   rdata = steer({DATA_W{1'b1}}, word, odd);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/main_bus_decoder.sv
module main_bus_decoder
  import mbd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VID_MASK   = 24'hE700E0,
  parameter logic [ADDR_W-1:0] VID_MATCH  = 24'hC00000,
  parameter logic [ADDR_W-1:0] OPEN_SPLIT = 24'hC00000,
  parameter logic [DATA_W-1:0] OPEN_WORD  = 16'h4E71,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] wram_rdata,
  input  logic [BYTE_W-1:0] cop_rdata,
  input  logic [BYTE_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic              busack,
  output logic              sel_rom,
  output logic              sel_wram,
  output logic              sel_cop,
  output logic              sel_io,
  output logic              sel_busctl,
  output logic              sel_video,
  output logic [1:0]        vid_port,
  output logic [LOC_W-1:0]  loc_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              lockup
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [NUM_SEL-1:0]     sel;
  src_e                   src;
  vport_e                 vport;
  logic                   lock_hit, open_hi, ack_page;
  logic [DATA_W-1:0]      merged;

  logic                   rd_en;
  logic [DATA_W-1:0]      rd_data_d, rd_data_q;
  logic                   rd_valid_d, rd_valid_q;
  logic                   lock_d, lock_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  mbd_region_decode #(
    .VID_MASK(VID_MASK), .VID_MATCH(VID_MATCH), .OPEN_SPLIT(OPEN_SPLIT)
  ) u_decode (
    .valid(req_valid), .write(req_write), .word(req_word), .addr(req_addr),
    .sel(sel), .src(src), .vport(vport), .lock_hit(lock_hit),
    .open_hi(open_hi), .ack_page(ack_page)
  );

  mbd_read_merge #(.OPEN_WORD(OPEN_WORD)) u_merge (
    .src(src), .word(req_word), .odd(req_addr[0]), .open_hi(open_hi),
    .ack_page(ack_page), .busack(busack), .rom_rdata(rom_rdata),
    .wram_rdata(wram_rdata), .cop_rdata(cop_rdata), .io_rdata(io_rdata),
    .vid_rdata(vid_rdata), .rdata(merged)
  );

  // next-state
  assign rd_en      = req_valid & ~req_write;
  assign rd_data_d  = rd_en ? merged : rd_data_q;
  assign rd_valid_d = rd_en;
  assign lock_d     = lock_q | lock_hit;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      lock_q     <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
      lock_q     <= lock_d;
    end
  end

  assign sel_rom    = sel[SEL_ROM];
  assign sel_wram   = sel[SEL_WRAM];
  assign sel_cop    = sel[SEL_COP];
  assign sel_io     = sel[SEL_IO];
  assign sel_busctl = sel[SEL_BUSCTL];
  assign sel_video  = sel[SEL_VIDEO];
  assign vid_port   = vport;
  assign loc_addr   = req_addr[LOC_W-1:0];
  assign out_wdata  = req_word ? req_wdata
                               : {req_wdata[BYTE_W-1:0], req_wdata[BYTE_W-1:0]};
  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
  assign lockup     = lock_q;
endmodule

// File: rtl/main_bus_decoder_chk.sv
module main_bus_decoder_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        req_valid,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic [5:0]  sels,
  input logic        rd_valid,
  input logic        lockup
);
  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(sels));
  // R1
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |-> sels == 6'd0);
  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_write) |=> rd_valid);
  // R3
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_write) |=> !rd_valid);
  // R11
  lockup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    lockup |=> lockup);
  // R10
  region4_lock_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_addr[23:21] == 3'd4) |=> lockup);
  // R12
  rom_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_write && req_addr[23:22] == 2'd0) |-> sels == 6'd0);
endmodule

bind main_bus_decoder main_bus_decoder_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr),
  .sels({sel_video, sel_busctl, sel_io, sel_cop, sel_wram, sel_rom}),
  .rd_valid(rd_valid), .lockup(lockup)
);

// File: tb/main_bus_decoder_tb_top.sv
module main_bus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word, busack;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rom_rdata, wram_rdata, vid_rdata;
  logic [7:0]  cop_rdata, io_rdata;
  logic        sel_rom, sel_wram, sel_cop, sel_io, sel_busctl, sel_video;
  logic [1:0]  vid_port;
  logic [15:0] loc_addr, out_wdata, rd_data;
  logic        rd_valid, lockup;
  logic [5:0]  sels;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  main_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rom_rdata(rom_rdata), .wram_rdata(wram_rdata), .cop_rdata(cop_rdata),
    .io_rdata(io_rdata), .vid_rdata(vid_rdata), .busack(busack),
    .sel_rom(sel_rom), .sel_wram(sel_wram), .sel_cop(sel_cop),
    .sel_io(sel_io), .sel_busctl(sel_busctl), .sel_video(sel_video),
    .vid_port(vid_port), .loc_addr(loc_addr), .out_wdata(out_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .lockup(lockup)
  );

  assign sels = {sel_video, sel_busctl, sel_io, sel_cop, sel_wram, sel_rom};

  // {write, word, addr, wdata, sels{vid,bus,io,cop,wram,rom}, port, rdata, req}
  localparam int NV = 32;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0,1'b1,24'h000100,16'h0,6'b000001,2'd0,16'hA1B2,4'd1},  // R1 rom word
    {1'b0,1'b0,24'h200100,16'h0,6'b000001,2'd0,16'h00A1,4'd4},  // R4 even byte
    {1'b0,1'b0,24'h000101,16'h0,6'b000001,2'd0,16'h00B2,4'd4},  // R4 odd byte
    {1'b0,1'b1,24'hE12344,16'h0,6'b000010,2'd0,16'hC3D4,4'd2},  // R2 wram
    {1'b0,1'b0,24'hFF2345,16'h0,6'b000010,2'd0,16'h00D4,4'd2},  // R2 mirror
    {1'b0,1'b0,24'hA01234,16'h0,6'b000100,2'd0,16'h005E,4'd5},  // R5 cop byte
    {1'b0,1'b1,24'hA01234,16'h0,6'b000100,2'd0,16'h5E5E,4'd5},  // R5 cop word
    {1'b0,1'b0,24'hA10003,16'h0,6'b001000,2'd0,16'h006F,4'd5},  // R5 io byte
    {1'b0,1'b1,24'hA10002,16'h0,6'b001000,2'd0,16'h6F6F,4'd5},  // R5 io word
    {1'b0,1'b1,24'hA11100,16'h0,6'b010000,2'd0,16'h4F00,4'd14}, // R14 word
    {1'b0,1'b0,24'hA11100,16'h0,6'b010000,2'd0,16'h004F,4'd14}, // R14 even
    {1'b0,1'b0,24'hA11101,16'h0,6'b010000,2'd0,16'h0000,4'd14}, // R14 odd
    {1'b0,1'b1,24'h400000,16'h0,6'b000000,2'd0,16'h4E00,4'd6},  // R6 rgn2
    {1'b0,1'b0,24'h600000,16'h0,6'b000000,2'd0,16'h004E,4'd6},  // R6 rgn3
    {1'b0,1'b1,24'hA10040,16'h0,6'b000000,2'd0,16'h4E00,4'd6},  // R6 page0
    {1'b0,1'b1,24'hC00000,16'h0,6'b100000,2'd0,16'hF3A7,4'd8},  // R8 data
    {1'b0,1'b0,24'hC00003,16'h0,6'b100000,2'd0,16'h00A7,4'd8},  // R8 data odd
    {1'b0,1'b1,24'hC00004,16'h0,6'b100000,2'd1,16'h4FA7,4'd9},  // R9 ctrl word
    {1'b0,1'b0,24'hC00006,16'h0,6'b100000,2'd1,16'h004F,4'd9},  // R9 ctrl even
    {1'b0,1'b0,24'hC00005,16'h0,6'b100000,2'd1,16'h00A7,4'd9},  // R9 ctrl odd
    {1'b0,1'b1,24'hC00008,16'h0,6'b100000,2'd2,16'hF3A7,4'd8},  // R8 hv
    {1'b0,1'b1,24'hC00018,16'h0,6'b000000,2'd0,16'h4E71,4'd6},  // R6 high open
    {1'b0,1'b0,24'hC0001B,16'h0,6'b000000,2'd0,16'h0071,4'd6},  // R6 odd
    {1'b0,1'b1,24'hD8FF00,16'h0,6'b100000,2'd0,16'hF3A7,4'd7},  // R7 mirror
    {1'b1,1'b1,24'hE00010,16'h1234,6'b000010,2'd0,16'h0,4'd1},  // R1 wram wr
    {1'b1,1'b1,24'h000010,16'h1234,6'b000000,2'd0,16'h0,4'd12}, // R12 rom wr
    {1'b1,1'b1,24'h600000,16'h1234,6'b000000,2'd0,16'h0,4'd12}, // R12 rgn3
    {1'b1,1'b0,24'hC00010,16'h0012,6'b000000,2'd0,16'h0,4'd12}, // R12 tone even
    {1'b1,1'b0,24'hC00011,16'h0012,6'b100000,2'd3,16'h0,4'd8},  // R8 tone odd
    {1'b1,1'b1,24'hC00004,16'h8123,6'b100000,2'd1,16'h0,4'd8},  // R8 ctrl wr
    {1'b1,1'b0,24'hA10002,16'h0055,6'b000000,2'd0,16'h0,4'd12}, // R12 io even
    {1'b1,1'b1,24'hC0001C,16'h1234,6'b000000,2'd0,16'h0,4'd12}  // R12 unused
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input bit wd, input logic [23:0] a,
                       input logic [15:0] wdat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd;
    req_addr = a; req_wdata = wdat;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic lock_case(input bit wr, input bit wd, input logic [23:0] a,
                           input logic [15:0] exp_rd, input string what);
    do_reset();
    drive(wr, wd, a, 16'h0);
    check(sels == 6'd0, "R10", {what, " sel"}, 32'(sels), 32'd0);
    idle();
    check(lockup == 1'b1, "R10", {what, " lockup"}, 32'(lockup), 32'd1);
    if (!wr) check(rd_data == exp_rd, "R10", {what, " data"}, 32'(rd_data),
                   32'(exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; busack = 1'b1;
    rom_rdata = 16'hA1B2; wram_rdata = 16'hC3D4; cop_rdata = 8'h5E;
    io_rdata = 8'h6F; vid_rdata = 16'hF3A7;
    do_reset();

    // reset state (R3, R11, R1)
    check(rd_valid == 1'b0, "R3", "reset rd_valid", 32'(rd_valid), 32'd0);
    check(lockup == 1'b0, "R11", "reset lockup", 32'(lockup), 32'd0);
    req_addr = 24'h000100;
    #1;
    check(sels == 6'd0, "R1", "idle select", 32'(sels), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[3:0]);
      drive(v[69], v[68], v[67:44], v[43:28]);
      check(sels == v[27:22], tag, $sformatf("vec%0d sel", i),
            32'(sels), 32'(v[27:22]));
      if (v[27])
        check(vid_port == v[21:20], tag, $sformatf("vec%0d port", i),
              32'(vid_port), 32'(v[21:20]));
      idle();
      check(rd_valid == !v[69], "R3", $sformatf("vec%0d rd_valid", i),
            32'(rd_valid), 32'(!v[69]));
      if (!v[69])
        check(rd_data == v[19:4], tag, $sformatf("vec%0d data", i),
              32'(rd_data), 32'(v[19:4]));
      check(lockup == 1'b0, "R11", $sformatf("vec%0d no lockup", i),
            32'(lockup), 32'd0);
    end

    // R2 local address mirror
    drive(1'b0, 1'b1, 24'hFF2344, 16'h0);
    check(loc_addr == 16'h2344, "R2", "loc_addr", 32'(loc_addr), 32'h2344);
    // R13 write lane handling
    drive(1'b1, 1'b0, 24'hC00011, 16'h9942);
    check(out_wdata == 16'h4242, "R13", "byte dup", 32'(out_wdata), 32'h4242);
    drive(1'b1, 1'b1, 24'hC00004, 16'h8123);
    check(out_wdata == 16'h8123, "R13", "word pass", 32'(out_wdata), 32'h8123);
    // R14 busack low
    busack = 1'b0;
    drive(1'b0, 1'b1, 24'hA11100, 16'h0);
    idle();
    check(rd_data == 16'h4E00, "R14", "busack low", 32'(rd_data), 32'h4E00);
    busack = 1'b1;

    // R10 lockup sources
    lock_case(1'b0, 1'b1, 24'h800000, 16'hFFFF, "region4 read");
    lock_case(1'b1, 1'b1, 24'h800000, 16'h0, "region4 write");
    lock_case(1'b0, 1'b0, 24'hC00011, 16'h00FF, "tone read");
    lock_case(1'b1, 1'b1, 24'hC0000C, 16'h0, "hv write");
    lock_case(1'b0, 1'b1, 24'hC10000, 16'hFFFF, "outside window");
    lock_case(1'b0, 1'b1, 24'hA14000, 16'hFFFF, "bad page");

    // R11 sticky and decoding continues
    repeat (3) @(negedge clk);
    check(lockup == 1'b1, "R11", "sticky", 32'(lockup), 32'd1);
    drive(1'b0, 1'b1, 24'hE00000, 16'h0);
    check(sel_wram == 1'b1, "R11", "decode after lockup", 32'(sel_wram), 32'd1);
    idle();
    check(rd_data == 16'hC3D4, "R11", "data after lockup", 32'(rd_data),
          32'hC3D4);
    check(lockup == 1'b1, "R11", "still set", 32'(lockup), 32'd1);
    do_reset();
    check(lockup == 1'b0, "R11", "cleared by reset", 32'(lockup), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule